// File: doc/BRIEF.md
# Byte boundary aligner

After a parallel-to-serial-to-parallel hop, the byte framing of a group of 8-bit receive lanes can be shifted by an unknown number of bits. This block recovers that framing. One lane carries a marker that sits at all zeros until the transmitter starts, then goes to all ones. The marker's first nonzero word shows how far the framing has slipped. The block counts the zero bits above the first one in that word, stores the count as a bit shift and locks.

After it locks, the block applies that one shift to every data lane. It does this with a funnel selection over the previous and current word of each lane. It also raises a valid flag, which the receive side uses to start its local expected-pattern generator. The lock is held until reset. Tracking slips that happen after lock is left to a later reset.

Top module: `byte_boundary_aligner`

## Requirements
- R1: While reset is asserted, and after it is released until lock, `valid_o` is 0, `shift_o` is 0 and every word of `aligned_o` is 0.
- R2: A marker word of all zeros never causes a lock. `valid_o` and `shift_o` stay 0 for any number of such words.
- R3: The shift latched on the first nonzero marker word equals the number of consecutive zero bits counted down from bit 7 (the MSB) to the highest 1 bit. Its range is 0 to 7. A first marker word of 8'hFF, including one seen on the first cycle after reset, gives 0.
- R4: `valid_o` rises in the cycle that follows the one in which the first nonzero marker word is presented. It then stays high until reset.
- R5: After lock, `shift_o` keeps its latched value whatever the marker lane carries, including zeros and other nonzero patterns.
- R6: While `valid_o` is high, each aligned word for shift s is bits [15-s:8-s] of the 16-bit value {previous word of that lane, current word of that lane}. The previous word is the one presented one cycle earlier. The current word passes through combinationally. The first aligned word therefore uses the lane word presented together with the locking marker as its upper half.
- R7: Lane k uses bits [8k+7:8k] at both `lane_data_i` and `aligned_o`. All lanes use the same latched shift.
- R8: While `valid_o` is low, every aligned word is 0, whatever the data lanes carry.
- R9: Asserting reset after lock clears the lock and the shift. The next nonzero marker word after release then sets a new shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| marker_i | input | WORD_W | Marker lane word |
| lane_data_i | input | LANES*WORD_W | Packed data lane words, lane k at bits [k*WORD_W +: WORD_W] |
| aligned_o | output | LANES*WORD_W | Realigned data lane words, same packing |
| shift_o | output | $clog2(WORD_W) | Latched bit shift |
| valid_o | output | 1 | High once the shift is locked |

## Verification
The bench builds the block with three data lanes and 8-bit words. This keeps the lane loop small enough to check every lane on every cycle, and it still exercises lane 0, an interior lane and the top lane of the packing. At this word width, all 255 nonzero first-marker values can be swept, each after its own reset. That covers every shift value and every pattern of ones below the leading one. Each sweep point is followed by random marker traffic, to confirm the lock holds. Separate runs for each shift keep the marker at 8'hFF and then drop it to zero, and one run locks on the very first cycle after reset.

// File: rtl/align_pkg.sv
package align_pkg;

    typedef enum logic {
        SEEK = 1'b0,
        HELD = 1'b1
    } lock_state_e;

endpackage

// File: rtl/align_marker_detect.sv
module align_marker_detect
    import align_pkg::*;
#(
    parameter int WORD_W  = 8,
    parameter int SHIFT_W = $clog2(WORD_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  marker_i,
    output logic [SHIFT_W-1:0] shift_o,
    output logic               locked_o
);

    typedef struct packed {
        lock_state_e        state;
        logic [SHIFT_W-1:0] shift;
    } det_state_t;

    det_state_t         st_d, st_q;
    logic [SHIFT_W-1:0] lead_d;

    always_comb begin
        lead_d = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (marker_i[i]) begin
                lead_d = SHIFT_W'(WORD_W - 1 - i);
            end
        end
        st_d = st_q;
        if (st_q.state == SEEK && |marker_i) begin
            st_d.state = HELD;
            st_d.shift = lead_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: SEEK, shift: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign shift_o  = st_q.shift;
    assign locked_o = (st_q.state == HELD);

    // R2
    no_lock_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_o && marker_i == '0) |=> !locked_o);

    // R4
    lock_on_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_o && marker_i != '0) |=> locked_o);

    // R4
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o);

    // R5
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> $stable(shift_o));

    // R3
    msb_one_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_o && marker_i[WORD_W-1]) |=> shift_o == '0);

endmodule

// File: rtl/align_lane_funnel.sv
module align_lane_funnel #(
    parameter int WORD_W  = 8,
    parameter int SHIFT_W = $clog2(WORD_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  word_i,
    input  logic [SHIFT_W-1:0] shift_i,
    input  logic               valid_i,
    output logic [WORD_W-1:0]  aligned_o
);

    localparam logic [SHIFT_W:0] WORD_SPAN = (SHIFT_W + 1)'(WORD_W);
    localparam logic [SHIFT_W-1:0] SHIFT_MAX = SHIFT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] prev;
    } lane_state_t;

    lane_state_t         st_d, st_q;
    logic [2*WORD_W-1:0] window;
    logic [2*WORD_W-1:0] moved;
    logic [SHIFT_W:0]    rsh;

    always_comb begin
        st_d.prev = word_i;
        window    = {st_q.prev, word_i};
        rsh       = WORD_SPAN - {1'b0, shift_i};
        moved     = window >> rsh;
        aligned_o = valid_i ? moved[WORD_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    zero_shift_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && shift_i == '0) |-> aligned_o == $past(word_i));

    // R6
    max_shift_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && shift_i == SHIFT_MAX) |-> aligned_o[WORD_W-1] == $past(word_i[0]));

endmodule

// File: rtl/byte_boundary_aligner.sv
module byte_boundary_aligner #(
    parameter int LANES   = 15,
    parameter int WORD_W  = 8,
    parameter int SHIFT_W = $clog2(WORD_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [WORD_W-1:0]       marker_i,
    input  logic [LANES*WORD_W-1:0] lane_data_i,
    output logic [LANES*WORD_W-1:0] aligned_o,
    output logic [SHIFT_W-1:0]      shift_o,
    output logic                    valid_o
);

    logic [SHIFT_W-1:0] shift_w;
    logic               locked_w;

    align_marker_detect #(
        .WORD_W  (WORD_W),
        .SHIFT_W (SHIFT_W)
    ) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .marker_i (marker_i),
        .shift_o  (shift_w),
        .locked_o (locked_w)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        align_lane_funnel #(
            .WORD_W  (WORD_W),
            .SHIFT_W (SHIFT_W)
        ) u_funnel (
            .clk       (clk),
            .rst_n     (rst_n),
            .word_i    (lane_data_i[k*WORD_W +: WORD_W]),
            .shift_i   (shift_w),
            .valid_i   (locked_w),
            .aligned_o (aligned_o[k*WORD_W +: WORD_W])
        );
    end

    assign shift_o = shift_w;
    assign valid_o = locked_w;

    // R8
    idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (aligned_o == '0 && shift_o == '0));

    // R4
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(marker_i) != '0);

endmodule

// File: tb/byte_boundary_aligner_test.sv
module byte_boundary_aligner_test;

    localparam int LANES   = 3;
    localparam int WORD_W  = 8;
    localparam int SHIFT_W = 3;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [WORD_W-1:0]       marker = '0;
    logic [LANES*WORD_W-1:0] data = '0;
    logic [LANES*WORD_W-1:0] aligned;
    logic [SHIFT_W-1:0]      shift;
    logic                    valid;

    byte_boundary_aligner #(
        .LANES   (LANES),
        .WORD_W  (WORD_W),
        .SHIFT_W (SHIFT_W)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .marker_i    (marker),
        .lane_data_i (data),
        .aligned_o   (aligned),
        .shift_o     (shift),
        .valid_o     (valid)
    );

    always #10 clk = ~clk;

    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done  = 0;
    bit         exp_lock;
    int         exp_shift;
    int         lock_age;
    logic [7:0] prev [LANES];
    logic [31:0] rng = 32'h1234_5678;

    task automatic roll(output logic [7:0] b);
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        b = rng[7:0];
    endtask

    function automatic int lead_count(logic [7:0] m);
        int         n = 0;
        logic [7:0] t = m;
        while (n < 8 && !t[7]) begin
            t = t << 1;
            n++;
        end
        return n;
    endfunction

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(string req);
        @(posedge clk);
        #1;
        rst_n  = 1'b0;
        marker = '0;
        data   = '0;
        @(negedge clk);
        check(req, "valid in reset", 16'(valid), 16'h0);
        check(req, "shift in reset", 16'(shift), 16'h0);
        check(req, "aligned in reset", aligned[15:0], 16'h0);
        check(req, "aligned top lane in reset", 16'(aligned[23:16]), 16'h0);
        @(posedge clk);
        #1;
        rst_n    = 1'b1;
        exp_lock = 0;
        exp_shift = 0;
        lock_age = 0;
        for (int l = 0; l < LANES; l++) prev[l] = 8'h00;
    endtask

    task automatic cycle(input logic [7:0] m);
        logic [7:0]  cur [LANES];
        logic [15:0] w;
        logic [7:0]  e;
        string       tag;
        @(posedge clk);
        #1;
        marker = m;
        for (int l = 0; l < LANES; l++) begin
            roll(cur[l]);
            data[l*8 +: 8] = cur[l];
        end
        @(negedge clk);
        check(exp_lock ? "R4" : "R2", "valid", 16'(valid), 16'(exp_lock));
        tag = !exp_lock ? "R2" : (lock_age == 0 ? "R3" : "R5");
        check(tag, "shift", 16'(shift), exp_lock ? 16'(exp_shift) : 16'h0);
        for (int l = 0; l < LANES; l++) begin
            w = {prev[l], cur[l]};
            w = w << exp_shift;
            e = exp_lock ? w[15:8] : 8'h00;
            tag = !exp_lock ? "R8" : (l == 0 ? "R6" : "R7");
            check(tag, $sformatf("lane %0d", l), 16'(aligned[l*8 +: 8]), 16'(e));
        end
        if (exp_lock) lock_age++;
        if (!exp_lock && m != 8'h00) begin
            exp_lock  = 1;
            exp_shift = lead_count(m);
            lock_age  = 0;
        end
        for (int l = 0; l < LANES; l++) prev[l] = cur[l];
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        logic [7:0] rm;
        do_reset("R1");
        // R3: lock on the very first cycle after reset with 8'hFF
        cycle(8'hFF);
        repeat (3) cycle(8'hFF);
        // R3 R4 R5: sweep every nonzero first marker value
        for (int m = 1; m < 256; m++) begin
            do_reset("R9");
            cycle(8'h00);
            cycle(8'h00);
            cycle(8'(m));
            repeat (4) begin
                roll(rm);
                cycle(rm);
            end
        end
        // R2: long stretch of zero markers, then each shift with a clean edge
        for (int s = 0; s < 8; s++) begin
            do_reset("R9");
            repeat (6) cycle(8'h00);
            cycle(8'hFF >> s);
            repeat (10) cycle(8'hFF);
            repeat (4) cycle(8'h00);
        end
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R4 watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule